// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block sits behind a serial line receiver. It takes one recovered bit per accepted clock cycle and finds the frame boundary in a stream of 12-bit frames. Each frame is a high start bit, ten payload bits and a low stop bit. The low-to-high step from one frame's stop bit to the next frame's start bit is the embedded clock edge, and the block finds its bit position inside the frame. It does no oversampling: the bit-rate clock and a qualifier give it one bit per cycle in which `in_valid` is high.

**Searching.** While unlocked, the block looks at every bit position of a free-running 12-bit window as a possible edge position. A position is adopted only when it is the single position that has shown a rising transition in every one of `CONFIRM_FRAMES` windows in a row. A clean sync pattern locks quickly, and so does data whose extra transitions move around. A repeating pattern with several fixed rising transitions per frame is never adopted. Once the position is adopted, the active-low lock output goes low.

**Locked.** The block checks the edge at every frame boundary and delivers the payload words. Two missed edges in a row release the lock, and the search starts again without outside help.

**Stream interface.** The input is a stream with a valid qualifier and no ready signal, because a serial line cannot be paused. A cycle with `in_valid` low consumes nothing. The output is a word strobe `word_valid` with `word_data`, and it has no back-pressure. Each word is presented for one cycle, and the consumer must take it in that cycle. Words appear only while `lock_n` is low.

Top module: `frame_lock_detect`

## Requirements
- R1: After reset, `lock_n` is 1 and `word_valid` is 0.
- R2: With a sync frame (start 1, payload 0x01F with bit 0 sent first, stop 0) repeated on the line, `lock_n` stays 1 while fewer than 4 twelve-bit windows have been completed with a rising edge in them. It goes low at the clock edge that accepts the last bit of the 4th such window.
- R3: If a frame repeats with rising transitions at two fixed positions, `lock_n` never goes low. The test frame is start 1, payload 0x002, stop 0, which rises at the start bit and at payload bit 1.
- R4: Non-repeating payloads lock after exactly 4 windows when only the start-bit position rises in all of them. The test frames carry payloads 0x002, 0x008, 0x020 and 0x080, each with one extra rise at a different position.
- R5: While locked, each frame gives one word. Bit 0 of the word is the first bit after the start bit. `word_valid` pulses for one cycle, in the cycle after the last payload bit is accepted.
- R6: A single frame whose start bit is 0, or whose preceding stop bit is 1, does not release lock. A good boundary clears the miss count, so misses that are not consecutive never release lock.
- R7: A missed edge at two frame boundaries in a row sets `lock_n` to 1 at the clock edge that accepts the second bad start position. No word is produced for that frame or afterwards until lock returns.
- R8: After lock is lost, the search restarts by itself and locks again after 4 more qualifying windows.
- R9: Cycles with `in_valid` low consume no bit. They change neither the frame position, nor `lock_n`, nor the payload.
- R10: Lock is found at any start-bit offset within the window. The first word comes from the first frame whose start bit arrives after lock, so no partly captured word is ever emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Recovered serial bit |
| lock_n | output | 1 | Low while the frame position is locked |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | DATA_W | Payload bits, bit 0 received first |

## Verification
The bench aims at the places where the search and the tracker can disagree with the frame.

- A detector that counted frames with any rising edge, rather than keeping only the positions that survive every window, would lock on the two-transition repeating pattern. It would also lock one window early, or never, on the shifting-payload sequence.
- A tracker that drops on the first miss, or that forgets to clear its miss count, fails the isolated-miss run. A tracker that only checks the start bit misses the case where a bad stop bit is the first of two misses.
- Locking at an offset of five bits shows whether a word built partly from bits taken before lock leaks out.
- Idle gaps between bits show whether an unqualified cycle moves the frame position.

// File: rtl/flk_pkg.sv
package flk_pkg;

  // Framing overhead added around the payload: one start bit, one stop bit.
  localparam int FRAME_OVERHEAD = 2;

  // Tracker states. SETTLE: position adopted, first start bit not yet seen.
  typedef enum logic [1:0] {
    TRK_HUNT   = 2'd0,
    TRK_SETTLE = 2'd1,
    TRK_LOCKED = 2'd2
  } trk_state_t;

endpackage

// File: rtl/flk_edge_hunter.sv
module flk_edge_hunter #(
  parameter int FRAME_W = 12,
  parameter int CONFIRM = 4,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            in_valid,
  input  logic            rise,
  input  logic [PH_W-1:0] ph,
  output logic            found,
  output logic [PH_W-1:0] found_pos
);
  localparam int CNT_W = $clog2(CONFIRM + 1);

  logic [FRAME_W-1:0] seen_q, seen_now, survive_q, keep, base;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               frame_end, chain, single;

  always_comb begin
    seen_now = seen_q;
    if (rise) seen_now[ph] = 1'b1;
    keep      = survive_q & seen_now;
    chain     = (cnt_q != '0) && (keep != '0);
    base      = chain ? keep : seen_now;
    cnt_n     = chain ? CNT_W'(cnt_q + 1'b1) : CNT_W'(seen_now != '0);
    single    = (base != '0) && ((base & (base - 1'b1)) == '0);
    frame_end = in_valid && (int'(ph) == FRAME_W - 1);
    found     = enable && frame_end && (int'(cnt_n) == CONFIRM) && single;
    found_pos = '0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (base[i]) found_pos = PH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= '0;
      survive_q <= '0;
      cnt_q     <= '0;
    end else if (!enable) begin
      seen_q    <= '0;
      survive_q <= '0;
      cnt_q     <= '0;
    end else if (in_valid) begin
      if (frame_end) begin
        seen_q <= '0;
        if (found) begin
          survive_q <= '0;
          cnt_q     <= '0;
        end else if (int'(cnt_n) >= CONFIRM) begin
          // Several positions survived the whole run: start over from this window.
          survive_q <= seen_now;
          cnt_q     <= CNT_W'(seen_now != '0);
        end else begin
          survive_q <= base;
          cnt_q     <= cnt_n;
        end
      end else begin
        seen_q <= seen_now;
      end
    end
  end

  // R2/R8: search history is discarded while the tracker holds lock.
  a_r8_idle_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

endmodule

// File: rtl/flk_frame_tracker.sv
module flk_frame_tracker
  import flk_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int FRAME_W    = 12,
  parameter int PH_W       = 4,
  parameter int MISS_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              rise,
  input  logic [PH_W-1:0]   ph,
  input  logic              found,
  input  logic [PH_W-1:0]   found_pos,
  output logic              locked,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  trk_state_t        st;
  logic [PH_W-1:0]   anchor;
  logic [MW-1:0]     misses;
  logic [DATA_W-1:0] shreg;
  logic [PH_W-1:0]   rel;

  always_comb begin
    rel = PH_W'((int'(ph) - int'(anchor) + FRAME_W) % FRAME_W);
  end

  assign locked = (st != TRK_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= TRK_HUNT;
      anchor     <= '0;
      misses     <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (st == TRK_HUNT) begin
        if (found) begin
          st     <= TRK_SETTLE;
          anchor <= found_pos;
          misses <= '0;
        end
      end else if (in_valid) begin
        if (rel == '0) begin
          if (rise) begin
            misses <= '0;
            st     <= TRK_LOCKED;
          end else if (int'(misses) == MISS_LIMIT - 1) begin
            misses <= '0;
            st     <= TRK_HUNT;
          end else begin
            misses <= MW'(misses + 1'b1);
            st     <= TRK_LOCKED;
          end
        end else if (int'(rel) <= DATA_W) begin
          shreg <= {in_bit, shreg[DATA_W-1:1]};
          if (int'(rel) == DATA_W && st == TRK_LOCKED) begin
            word_valid <= 1'b1;
            word_data  <= {in_bit, shreg[DATA_W-1:1]};
          end
        end
      end
    end
  end

  // R7: lock is only released on an accepted bit.
  a_r7_drop_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid));

  // R5: one strobe per frame, never back to back.
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

endmodule

// File: rtl/frame_lock_detect.sv
module frame_lock_detect
  import flk_pkg::*;
#(
  parameter int DATA_W         = 10,
  parameter int CONFIRM_FRAMES = 4,
  parameter int MISS_LIMIT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              lock_n,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  localparam int FRAME_W = DATA_W + FRAME_OVERHEAD;
  localparam int PH_W    = $clog2(FRAME_W);

  logic            prev_q;
  logic [PH_W-1:0] ph_q;
  logic            rise, found, locked;
  logic [PH_W-1:0] found_pos;

  // A rising step between two accepted bits.
  assign rise = in_valid & ~prev_q & in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      ph_q   <= '0;
    end else if (in_valid) begin
      prev_q <= in_bit;
      ph_q   <= (int'(ph_q) == FRAME_W - 1) ? '0 : PH_W'(ph_q + 1'b1);
    end
  end

  flk_edge_hunter #(
    .FRAME_W (FRAME_W),
    .CONFIRM (CONFIRM_FRAMES),
    .PH_W    (PH_W)
  ) u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (~locked),
    .in_valid  (in_valid),
    .rise      (rise),
    .ph        (ph_q),
    .found     (found),
    .found_pos (found_pos)
  );

  flk_frame_tracker #(
    .DATA_W     (DATA_W),
    .FRAME_W    (FRAME_W),
    .PH_W       (PH_W),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_bit     (in_bit),
    .rise       (rise),
    .ph         (ph_q),
    .found      (found),
    .found_pos  (found_pos),
    .locked     (locked),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  assign lock_n = ~locked;

  // R5: words only while locked.
  a_r5_word_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !lock_n);

  // R9: an unqualified cycle moves neither position nor lock.
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ph_q) && $stable(lock_n)));

endmodule

// File: tb/sim_frame_lock_detect.sv
`timescale 1ns/1ps
module sim_frame_lock_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       lock_n;
  logic       word_valid;
  logic [9:0] word_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [9:0] got_q[$];

  always #2 clk = ~clk;

  frame_lock_detect u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .lock_n(lock_n), .word_valid(word_valid), .word_data(word_data)
  );

  always @(negedge clk) if (rst_n && word_valid) got_q.push_back(word_data);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    got_q.delete();
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1;
    in_bit = b;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    in_bit = ~in_bit;
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [9:0] d, input logic st, input logic sp, input bit gaps);
    send_bit(st);
    if (gaps) idle_cycle();
    for (int i = 0; i < 10; i++) begin
      send_bit(d[i]);
      if (gaps) idle_cycle();
    end
    send_bit(sp);
  endtask

  task automatic lock_sync(input int lead);
    do_reset();
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    for (int f = 0; f < 4; f++) send_frame(10'h01F, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lock_n", lock_n, 1);
    chk("R1 word_valid", word_valid, 0);
  endtask

  task automatic t_sync_lock();
    do_reset();
    send_bit(1'b0);
    for (int f = 0; f < 3; f++) send_frame(10'h01F, 1'b1, 1'b0, 1'b0);
    chk("R2 unlocked after 3", lock_n, 1);
    for (int i = 0; i < 10; i++) send_bit(i < 5);
    chk("R2 unlocked one bit short", lock_n, 1);
    send_bit(1'b0);
    chk("R2 locked at 4th window", lock_n, 0);
    send_bit(1'b0);
    chk("R2 no word yet", got_q.size(), 0);
  endtask

  task automatic t_data();
    lock_sync(1);
    got_q.delete();
    send_frame(10'h001, 1'b1, 1'b0, 1'b0);
    send_frame(10'h2A5, 1'b1, 1'b0, 1'b0);
    send_frame(10'h0F3, 1'b1, 1'b0, 1'b1);
    send_frame(10'h35A, 1'b1, 1'b0, 1'b0);
    chk("R5 word count", got_q.size(), 4);
    if (got_q.size() == 4) begin
      chk("R5 bit0 first", got_q[0], 10'h001);
      chk("R5 word 2A5", got_q[1], 10'h2A5);
      chk("R9 gapped word", got_q[2], 10'h0F3);
      chk("R5 word 35A", got_q[3], 10'h35A);
    end
    chk("R9 lock kept", lock_n, 0);
  endtask

  task automatic t_miss_single();
    lock_sync(1);
    send_frame(10'h155, 1'b0, 1'b0, 1'b0);
    chk("R6 one miss keeps lock", lock_n, 0);
    send_frame(10'h0AA, 1'b1, 1'b0, 1'b0);
    send_frame(10'h155, 1'b0, 1'b0, 1'b0);
    send_frame(10'h0AA, 1'b1, 1'b0, 1'b0);
    send_frame(10'h0AA, 1'b1, 1'b1, 1'b0);
    send_frame(10'h0AA, 1'b1, 1'b0, 1'b0);
    chk("R6 spaced misses keep lock", lock_n, 0);
  endtask

  task automatic t_double_miss();
    lock_sync(1);
    send_frame(10'h0AA, 1'b1, 1'b0, 1'b0);
    got_q.delete();
    send_frame(10'h111, 1'b1, 1'b1, 1'b0);
    send_frame(10'h222, 1'b1, 1'b0, 1'b0);
    chk("R7 one miss still locked", lock_n, 0);
    send_bit(1'b0);
    chk("R7 lost at 2nd miss", lock_n, 1);
    for (int i = 0; i < 11; i++) send_bit(1'b0);
    chk("R7 words before loss", got_q.size(), 2);
    if (got_q.size() == 2) chk("R7 bad-stop word", got_q[0], 10'h111);
    for (int f = 0; f < 3; f++) send_frame(10'h01F, 1'b1, 1'b0, 1'b0);
    chk("R8 not yet relocked", lock_n, 1);
    chk("R7 no words unlocked", got_q.size(), 2);
    send_frame(10'h01F, 1'b1, 1'b0, 1'b0);
    chk("R8 relocked", lock_n, 0);
  endtask

  task automatic t_rmt();
    do_reset();
    send_bit(1'b0);
    for (int f = 0; f < 12; f++) send_frame(10'h002, 1'b1, 1'b0, 1'b0);
    chk("R3 repeating pattern rejected", lock_n, 1);
    chk("R3 no words", got_q.size(), 0);
  endtask

  task automatic t_varied();
    logic [9:0] pat [4] = '{10'h002, 10'h008, 10'h020, 10'h080};
    do_reset();
    send_bit(1'b0);
    for (int f = 0; f < 3; f++) send_frame(pat[f], 1'b1, 1'b0, 1'b0);
    chk("R4 unlocked after 3", lock_n, 1);
    send_frame(pat[3], 1'b1, 1'b0, 1'b0);
    chk("R4 locked after 4", lock_n, 0);
  endtask

  task automatic t_offset();
    lock_sync(5);
    chk("R10 locked at offset", lock_n, 0);
    chk("R10 no partial word", got_q.size(), 0);
    got_q.delete();
    send_frame(10'h3C1, 1'b1, 1'b0, 1'b0);
    send_frame(10'h07E, 1'b1, 1'b0, 1'b0);
    send_bit(1'b1);
    chk("R10 word count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk("R10 word 3C1", got_q[0], 10'h3C1);
      chk("R10 word 07E", got_q[1], 10'h07E);
    end
  endtask

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sync_lock();
    t_data();
    t_miss_single();
    t_double_miss();
    t_rmt();
    t_varied();
    t_offset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule